// File: doc/BRIEF.md
# I2C Master Bus-Condition Timing Generator

This block is an I2C master engine that drives the open-drain SCL and SDA lines from a single system clock. It produces start, repeated-start and stop conditions and nine-clock byte transfers: eight data bits and one acknowledge bit. Every edge it places on the bus sits a fixed number of system-clock cycles away from the previous one. All of these distances come from one programmable SCL period, split in fixed fractions with small fixed offsets.

The surrounding logic drives a period value and pulses one-cycle command strobes while `ready_o` is high. The outputs are output-enables: a 1 pulls the line low, and a 0 lets the pull-up raise it. The line levels come back through `scl_i` and `sda_i` and pass through one register stage. A stop that is requested while a start is still being driven is kept. It runs once the start has finished and both sampled lines read low.

Top module: `i2cm_timing_master`

## Requirements
- R1: The effective SCL period P is `period_i` clamped to the range 28..256 cycles. It is latched when a start is accepted from idle, and later changes to `period_i` do not affect that transaction.
- R2: Let H = floor(P/2) and L = P - H. Within a byte, every data and acknowledge bit holds SCL released for exactly H cycles and pulled low for exactly L cycles.
- R3: A start accepted from idle sets `sda_oe_o` and `busy_o` on the next edge while SCL stays released. `scl_oe_o` is set H-1 cycles later, and the engine then waits with both lines held low.
- R4: In a bit, SDA changes 3 cycles after SCL is pulled low and L-3 cycles before SCL is released. Data goes out MSB first, and a 0 bit sets `sda_oe_o`.
- R5: On the ninth bit of a write, SDA is released and `ack_o` takes the sampled line level (0 = ACK). On a read, bits 1-8 leave SDA released and the ninth bit drives SDA low unless `last_i` was 1. `rx_data_o` holds the eight sampled bits MSB first, which after a write is the byte as seen on the line.
- R6: A start given while waiting is a repeated start. After the 3-cycle hold, SDA is released. SCL is released L-3 cycles later and stays released with SDA high for P cycles. The sequence then continues as in R3.
- R7: A stop drives SDA low 3 cycles after the request and releases SCL L-3 cycles later. SDA is released H+2 cycles after SCL.
- R8: After a stop, both lines stay released for H cycles before `busy_o` clears. A start during that time is ignored, and SCL is never driven while `busy_o` is low.
- R9: A stop strobed while a start condition is being driven is kept. The stop sequence begins 2 cycles after SCL is pulled low, once both lines, sampled through one register stage, read low.
- R10: `ready_o` is high in idle, and while waiting with SCL held low and no kept stop. Commands given at other times have no effect. Only start is accepted in idle. While waiting, the priority is start, stop, write, read.
- R11: After reset, both output-enables are 0, `busy_o` is 0, `ready_o` is 1, `ack_o` is 1 and `rx_data_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| period_i | input | 9 | Requested SCL period in system-clock cycles |
| start_i | input | 1 | Start or repeated-start strobe |
| stop_i | input | 1 | Stop strobe |
| write_i | input | 1 | Write-byte strobe |
| read_i | input | 1 | Read-byte strobe |
| last_i | input | 1 | Read: answer NACK on this byte |
| data_i | input | 8 | Byte to transmit |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_oe_o | output | 1 | Pull SCL low |
| sda_oe_o | output | 1 | Pull SDA low |
| busy_o | output | 1 | Bus owned, from start until the end of the free time after stop |
| ready_o | output | 1 | Command may be strobed |
| rx_data_o | output | 8 | Sampled byte, MSB first |
| ack_o | output | 1 | Acknowledge level sampled on the last write |

## Verification
Each strobe is sampled on one edge, and the first changed output appears right after it. From there the bus shape follows as a string of segments whose lengths come from H, L and P. The one exception is a kept stop, which starts two cycles after SCL is pulled low because of the input register. When a command is issued, the bench pushes the expected output-enable and busy levels onto a queue, one entry per cycle, and compares one entry with the outputs on each falling clock edge. `ack_o` and `rx_data_o` settle on the edge that ends the ninth bit, so they are checked only after the queue has drained.

// File: rtl/i2cm_pkg.sv
`timescale 1ns/1ps
package i2cm_pkg;
  localparam int PER_MIN  = 28;
  localparam int PER_MAX  = 256;
  localparam int HOLD_CYC = 3;

  typedef enum logic [2:0] {
    ST_IDLE, ST_STA, ST_WAIT, ST_LHOLD, ST_LSET, ST_HIGH, ST_FREE
  } state_t;

  typedef enum logic [1:0] {OP_WR, OP_RD, OP_STOP, OP_RSTA} op_t;
endpackage

// File: rtl/i2cm_period.sv
`timescale 1ns/1ps
module i2cm_period #(
  parameter int PW   = 9,
  parameter int PMIN = 28,
  parameter int PMAX = 256
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [PW-1:0] per_i,
  output logic [PW-1:0] per_o,
  output logic [PW-1:0] hi_o,
  output logic [PW-1:0] lo_o
);
  localparam logic [PW-1:0] MinV = PW'(PMIN);
  localparam logic [PW-1:0] MaxV = PW'(PMAX);

  logic [PW-1:0] clamp, per_q;

  always_comb begin
    if (per_i < MinV)      clamp = MinV;
    else if (per_i > MaxV) clamp = MaxV;
    else                   clamp = per_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     per_q <= MinV;
    else if (load_i) per_q <= clamp;
  end

  // new value visible in the loading cycle so the first segment uses it
  assign per_o = load_i ? clamp : per_q;
  assign hi_o  = per_o >> 1;
  assign lo_o  = per_o - hi_o;
endmodule

// File: rtl/i2cm_sync.sv
`timescale 1ns/1ps
module i2cm_sync #(
  parameter int W      = 2,
  parameter int STAGES = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] chain [STAGES+1];
  assign chain[0] = d_i;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain[s+1] <= '1;
      else         chain[s+1] <= chain[s];
    end
  end

  assign q_o = chain[STAGES];
endmodule

// File: rtl/i2cm_shift.sv
`timescale 1ns/1ps
module i2cm_shift #(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [DW-1:0] data_i,
  input  logic          shift_i,
  input  logic          sin_i,
  output logic          msb_o,
  output logic [DW-1:0] data_o
);
  logic [DW-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       sr_q <= '0;
    else if (load_i)   sr_q <= data_i;
    else if (shift_i)  sr_q <= {sr_q[DW-2:0], sin_i};
  end

  assign msb_o  = sr_q[DW-1];
  assign data_o = sr_q;
endmodule

// File: rtl/i2cm_timing_master.sv
`timescale 1ns/1ps
module i2cm_timing_master
  import i2cm_pkg::*;
#(
  parameter int DW = 8,
  parameter int PW = 9
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [PW-1:0] period_i,
  input  logic          start_i,
  input  logic          stop_i,
  input  logic          write_i,
  input  logic          read_i,
  input  logic          last_i,
  input  logic [DW-1:0] data_i,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          scl_oe_o,
  output logic          sda_oe_o,
  output logic          busy_o,
  output logic          ready_o,
  output logic [DW-1:0] rx_data_o,
  output logic          ack_o
);
  localparam int BCW = $clog2(DW + 1);
  localparam logic [BCW-1:0] LastBit = BCW'(DW);
  localparam logic [PW-1:0]  DHold   = PW'(HOLD_CYC - 1);

  state_t         state_q;
  op_t            op_q;
  logic [PW-1:0]  cnt_q;
  logic [BCW-1:0] bit_q;
  logic scl_q, sda_q, busy_q, stop_pend_q, last_q, ack_q;

  logic [PW-1:0] per, hi, lo;
  logic [PW-1:0] d_sta, d_lset, d_high, d_free;
  logic [1:0]    lines_s;
  logic          scl_s, sda_s;
  logic          cnt_zero, last_bit, sda_nxt, tx_msb;
  logic          per_load, sh_load, sh_en;
  logic          wait_cmd;

  assign per_load = (state_q == ST_IDLE) && start_i;

  i2cm_period #(.PW(PW), .PMIN(PER_MIN), .PMAX(PER_MAX)) i_period (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (per_load),
    .per_i  (period_i),
    .per_o  (per),
    .hi_o   (hi),
    .lo_o   (lo)
  );

  i2cm_sync #(.W(2), .STAGES(1)) i_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({scl_i, sda_i}),
    .q_o    (lines_s)
  );
  assign scl_s = lines_s[1];
  assign sda_s = lines_s[0];

  // segment lengths minus one (counter runs to zero)
  assign d_sta  = hi - PW'(2);
  assign d_lset = lo - PW'(HOLD_CYC + 1);
  assign d_free = hi - PW'(1);
  always_comb begin
    unique case (op_q)
      OP_STOP: d_high = hi + PW'(1);
      OP_RSTA: d_high = per - PW'(1);
      default: d_high = hi - PW'(1);
    endcase
  end

  assign cnt_zero = (cnt_q == '0);
  assign last_bit = (bit_q == LastBit);
  assign wait_cmd = (state_q == ST_WAIT) && !stop_pend_q;

  assign sh_load = wait_cmd && !start_i && !stop_i && write_i;
  assign sh_en   = (state_q == ST_HIGH) && cnt_zero && !last_bit &&
                   (op_q == OP_WR || op_q == OP_RD);

  i2cm_shift #(.DW(DW)) i_shift (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (sh_load),
    .data_i  (data_i),
    .shift_i (sh_en),
    .sin_i   (sda_s),
    .msb_o   (tx_msb),
    .data_o  (rx_data_o)
  );

  always_comb begin
    unique case (op_q)
      OP_WR:   sda_nxt = last_bit ? 1'b0 : ~tx_msb;
      OP_RD:   sda_nxt = last_bit ? ~last_q : 1'b0;
      OP_STOP: sda_nxt = 1'b1;
      default: sda_nxt = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      op_q        <= OP_STOP;
      cnt_q       <= '0;
      bit_q       <= '0;
      scl_q       <= 1'b0;
      sda_q       <= 1'b0;
      busy_q      <= 1'b0;
      stop_pend_q <= 1'b0;
      last_q      <= 1'b0;
      ack_q       <= 1'b1;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            state_q     <= ST_STA;
            cnt_q       <= d_sta;
            sda_q       <= 1'b1;
            busy_q      <= 1'b1;
            stop_pend_q <= 1'b0;
          end
        end
        ST_STA: begin
          if (stop_i) stop_pend_q <= 1'b1;
          if (cnt_zero) begin
            state_q <= ST_WAIT;
            scl_q   <= 1'b1;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        ST_WAIT: begin
          if (stop_pend_q) begin
            // kept stop waits until both lines are seen low
            if (!scl_s && !sda_s) begin
              stop_pend_q <= 1'b0;
              op_q        <= OP_STOP;
              state_q     <= ST_LHOLD;
              cnt_q       <= DHold;
            end
          end else if (start_i) begin
            op_q    <= OP_RSTA;
            state_q <= ST_LHOLD;
            cnt_q   <= DHold;
          end else if (stop_i) begin
            op_q    <= OP_STOP;
            state_q <= ST_LHOLD;
            cnt_q   <= DHold;
          end else if (write_i) begin
            op_q    <= OP_WR;
            bit_q   <= '0;
            state_q <= ST_LHOLD;
            cnt_q   <= DHold;
          end else if (read_i) begin
            op_q    <= OP_RD;
            last_q  <= last_i;
            bit_q   <= '0;
            state_q <= ST_LHOLD;
            cnt_q   <= DHold;
          end
        end
        ST_LHOLD: begin
          if (cnt_zero) begin
            state_q <= ST_LSET;
            cnt_q   <= d_lset;
            sda_q   <= sda_nxt;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        ST_LSET: begin
          if (cnt_zero) begin
            state_q <= ST_HIGH;
            cnt_q   <= d_high;
            scl_q   <= 1'b0;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        ST_HIGH: begin
          if (cnt_zero) begin
            unique case (op_q)
              OP_STOP: begin
                sda_q   <= 1'b0;
                state_q <= ST_FREE;
                cnt_q   <= d_free;
              end
              OP_RSTA: begin
                sda_q   <= 1'b1;
                state_q <= ST_STA;
                cnt_q   <= d_sta;
              end
              default: begin
                scl_q <= 1'b1;
                if (last_bit) begin
                  state_q <= ST_WAIT;
                  if (op_q == OP_WR) ack_q <= sda_s;
                end else begin
                  state_q <= ST_LHOLD;
                  cnt_q   <= DHold;
                  bit_q   <= bit_q + 1'b1;
                end
              end
            endcase
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        ST_FREE: begin
          if (cnt_zero) begin
            state_q <= ST_IDLE;
            busy_q  <= 1'b0;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign scl_oe_o = scl_q;
  assign sda_oe_o = sda_q;
  assign busy_o   = busy_q;
  assign ack_o    = ack_q;
  assign ready_o  = (state_q == ST_IDLE) || wait_cmd;
endmodule

// File: rtl/i2cm_timing_master_chk.sv
`timescale 1ns/1ps
module i2cm_timing_master_chk #(
  parameter int HALF_MIN = 14
) (
  input logic clk_i,
  input logic rst_ni,
  input logic scl_oe_o,
  input logic sda_oe_o,
  input logic busy_o,
  input logic ready_o
);
  logic [8:0] hi_cnt, lo_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_cnt <= '0;
      lo_cnt <= '0;
    end else begin
      hi_cnt <= scl_oe_o ? '0 : (hi_cnt == '1 ? hi_cnt : hi_cnt + 1'b1);
      lo_cnt <= !scl_oe_o ? '0 : (lo_cnt == '1 ? lo_cnt : lo_cnt + 1'b1);
    end
  end

  AST_START_SHAPE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> sda_oe_o && !scl_oe_o);  // R3

  AST_DATA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(scl_oe_o) |=> $stable(sda_oe_o));  // R4

  AST_IDLE_RELEASED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !scl_oe_o && !sda_oe_o);  // R8

  AST_READY_HOLDS_SCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o && busy_o |-> scl_oe_o);  // R10

  AST_SCL_HIGH_MIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(scl_oe_o) |-> hi_cnt >= 9'(HALF_MIN - 1));  // R2

  AST_SCL_LOW_MIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(scl_oe_o) |-> lo_cnt >= 9'(HALF_MIN));  // R2
endmodule

bind i2cm_timing_master i2cm_timing_master_chk i_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .scl_oe_o (scl_oe_o),
  .sda_oe_o (sda_oe_o),
  .busy_o   (busy_o),
  .ready_o  (ready_o)
);

// File: tb/test_i2cm_timing_master.sv
`timescale 1ns/1ps
module test_i2cm_timing_master;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [8:0] period_i = 9'd40;
  logic       start_i = 0, stop_i = 0, write_i = 0, read_i = 0, last_i = 0;
  logic [7:0] data_i = 8'h00;
  logic       scl_i, sda_i;
  logic       scl_oe, sda_oe, busy, ready, ack;
  logic [7:0] rx;

  int n_chk = 0;
  int n_err = 0;
  bit done = 0;

  always #10 clk = ~clk;  // 50 MHz

  // bus slave: presents bit sl_idx of sl_bits, advancing on each SCL fall
  logic       sl_clr = 1'b0;
  int         sl_idx = 9;
  logic [8:0] sl_bits = '1;
  always @(posedge scl_oe or posedge sl_clr) begin
    if (sl_clr) sl_idx = 0;
    else if (sl_idx < 9) sl_idx = sl_idx + 1;
  end
  wire sl_low = (sl_idx < 9) ? !sl_bits[8 - sl_idx] : 1'b0;
  assign scl_i = !scl_oe;
  assign sda_i = !(sda_oe || sl_low);

  i2cm_timing_master i_i2cm_timing_master (
    .clk_i(clk), .rst_ni(rst_n), .period_i(period_i),
    .start_i(start_i), .stop_i(stop_i), .write_i(write_i), .read_i(read_i),
    .last_i(last_i), .data_i(data_i), .scl_i(scl_i), .sda_i(sda_i),
    .scl_oe_o(scl_oe), .sda_oe_o(sda_oe), .busy_o(busy), .ready_o(ready),
    .rx_data_o(rx), .ack_o(ack)
  );

  // reference model: expected {scl_oe, sda_oe, busy} per cycle
  logic [2:0] q_lv[$];
  string      q_tag[$];
  logic [2:0] exp_lv = 3'b000;
  string      exp_tag = "R11";
  bit         m_sda = 0;
  int         pe = 28, hh = 14, ll = 14;

  task automatic push(int n, bit s, bit d, bit b, string t);
    for (int i = 0; i < n; i++) begin
      q_lv.push_back({s, d, b});
      q_tag.push_back(t);
    end
    if (n > 0) m_sda = d;
  endtask

  task automatic chk(bit ok, string t, int act, int expv);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", t, act, expv);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (q_lv.size() > 0) begin
        exp_lv  = q_lv.pop_front();
        exp_tag = q_tag.pop_front();
      end
      chk({scl_oe, sda_oe, busy} === exp_lv, exp_tag, {scl_oe, sda_oe, busy}, exp_lv);
    end
  end

  task automatic strobe(int c);
    @(negedge clk); #1;
    case (c)
      0: start_i = 1;
      1: stop_i  = 1;
      2: write_i = 1;
      default: read_i = 1;
    endcase
  endtask

  task automatic unstrobe;
    @(negedge clk); #1;
    start_i = 0; stop_i = 0; write_i = 0; read_i = 0;
  endtask

  task automatic drain;
    while (q_lv.size() > 0) begin
      @(negedge clk); #1;
    end
  endtask

  task automatic stop_seq(string t1, string t2);
    push(3, 1, m_sda, 1, t1);
    push(ll - 3, 1, 1, 1, t1);
    push(hh + 2, 0, 1, 1, t1);
    push(hh, 0, 0, 1, t2);
    push(1, 0, 0, 0, t2);
  endtask

  task automatic do_start(int p, bit pend);
    period_i = p[8:0];
    pe = (p < 28) ? 28 : ((p > 256) ? 256 : p);  // R1 clamp
    hh = pe / 2;
    ll = pe - hh;
    strobe(0);
    push(hh - 1, 0, 1, 1, "R3");
    push(1, 1, 1, 1, "R3");
    unstrobe;
    if (pend) begin
      strobe(1);  // stop during start, R9
      push(1, 1, 1, 1, "R9");
      stop_seq("R9", "R9");
      unstrobe;
      drain;
      chk(busy == 0, "R9 busy", busy, 0);
    end else begin
      drain;
      chk(ready == 1, "R10 ready", ready, 1);
      chk(busy == 1, "R3 busy", busy, 1);
    end
  endtask

  task automatic do_byte(bit wr, logic [7:0] dat, bit last, bit ackv);
    bit d;
    sl_bits = wr ? {8'hFF, ackv} : {dat, 1'b1};
    sl_clr = 1; #1 sl_clr = 0;
    data_i = dat;
    last_i = last;
    strobe(wr ? 2 : 3);
    for (int k = 0; k < 9; k++) begin
      if (wr) d = (k < 8) ? !dat[7-k] : 1'b0;
      else    d = (k < 8) ? 1'b0 : !last;
      push(3, 1, m_sda, 1, "R4");
      push(ll - 3, 1, d, 1, "R4");
      push(hh, 0, d, 1, "R2");
    end
    push(1, 1, d, 1, "R5");
    unstrobe;
    chk(ready == 0, "R10 ready mid-byte", ready, 0);
    strobe(1);  // ignored while busy in a byte, R10
    unstrobe;
    data_i = 8'h00;
    drain;
    if (wr) chk(ack == ackv, "R5 ack", ack, ackv);
    chk(rx == dat, "R5 rx", rx, dat);
  endtask

  task automatic do_rstart;
    strobe(0);
    push(3, 1, m_sda, 1, "R6");
    push(ll - 3, 1, 0, 1, "R6");
    push(pe, 0, 0, 1, "R6");
    push(hh - 1, 0, 1, 1, "R3");
    push(1, 1, 1, 1, "R3");
    unstrobe;
    drain;
  endtask

  task automatic do_stop(bit poke);
    strobe(1);
    stop_seq("R7", "R8");
    unstrobe;
    if (poke) begin
      while (q_lv.size() > 2) begin
        @(negedge clk); #1;
      end
      start_i = 1;  // ignored during bus free time, R8
      @(negedge clk); #1;
      start_i = 0;
    end
    drain;
    chk(busy == 0, "R8 busy", busy, 0);
    chk(ready == 1, "R8 ready", ready, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk({scl_oe, sda_oe, busy} == 3'b000, "R11 lines", {scl_oe, sda_oe, busy}, 0);
    chk(ready == 1, "R11 ready", ready, 1);
    chk(ack == 1, "R11 ack", ack, 1);
    chk(rx == 0, "R11 rx", rx, 0);
    #1 rst_n = 1;
    // R10: non-start commands in idle do nothing
    strobe(2); unstrobe;
    strobe(3); unstrobe;
    strobe(1); unstrobe;
    repeat (5) @(negedge clk);
    #1;
    chk(busy == 0 && ready == 1, "R10 idle ignore", {busy, ready}, 1);

    do_start(40, 0);
    do_byte(1, 8'hA5, 0, 0);
    do_byte(0, 8'h3C, 0, 0);
    do_rstart;
    do_byte(1, 8'h5A, 0, 1);
    do_stop(1);

    do_start(41, 0);       // odd period
    period_i = 9'd100;     // R1: no effect mid-transaction
    do_byte(0, 8'hC3, 1, 0);
    do_rstart;
    do_stop(0);

    do_start(10, 1);       // clamps to 28, kept stop R9
    do_start(300, 0);      // clamps to 256, R1
    do_byte(1, 8'h81, 0, 0);
    do_stop(0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++;
      n_err++;
      $display("FAIL R11 watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule